// File: doc/BRIEF.md
# Interrupt Status and Clear Controller

This block is the interrupt unit of a small video and I/O gate array. It gathers five maskable interrupt sources into a status byte. The sources are the vertical blanking point, a periodic clock tick, a transmit register that has emptied, a receive register that has filled, and a detected high tone on the tape input. Software picks the sources that may pull the single active-low IRQ line by writing an enable byte. It drops latched events by writing a separate clear byte.

The block also holds a non-maskable interrupt state. This state is set by a rising edge on `nmi_in` and stays set until software releases it through the clear byte. While it is set, the video fetch logic may not use memory, so `ram_access_ok` stays low even when a pixel fetch is requested. The vertical-blanking condition comes from the current video line number, not from a separate pulse.

Top module: `intc_top`

## Requirements
- R1: During and after reset, `status_rd` is 0, `irq_n` is 1, the enable byte is 0, and the NMI state is clear.
- R2: A write (`bus_we`=1) to offset 0 loads enable bits from `bus_wdata[6:2]`, using the same bit positions as the status byte. From the cycle after the write, `irq_n` is 0 exactly when some status bit in 2..6 is set together with its enable bit.
- R3: The status byte is laid out as follows. Bit 0 is the master flag, set when some enabled source is pending. Bit 1 reads 0. Bit 2 is vsync, bit 3 the clock tick, bit 4 transmit-empty, bit 5 receive-full, bit 6 high-tone, and bit 7 the NMI state.
- R4: Transmit-empty (bit 4) and receive-full (bit 5) are level conditions. Each shows the value its input had one cycle earlier.
- R5: The clock tick (bit 3) and high-tone (bit 6) are set by a rising edge of their inputs and stay set after the input falls. A clear-register write (offset 5) drops bit 3 when `bus_wdata[4]`=1 and bit 6 when `bus_wdata[6]`=1. When a new rising edge and a clear arrive in the same cycle, the flag ends up set.
- R6: The vsync flag (bit 2) is set on the cycle after `line_num` equals LAST_LINE. It is cleared on the cycle after `line_num` equals 0. It holds its value on any other line.
- R7: A rising edge on `nmi_in` sets the NMI state (bit 7). The state stays set whatever `nmi_in` does until a clear write has `bus_wdata[7]`=1, and a new edge in that same cycle wins. `ram_access_ok` equals `pix_fetch` while the NMI state is clear and is 0 while it is set.
- R8: Writes to any offset other than 0 and 5 change nothing. A clear write does not affect the enable byte or bits 2, 4 and 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register offset within the block |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| evt_rtc | input | 1 | Periodic clock tick source |
| evt_tx_empty | input | 1 | Transmit register empty level |
| evt_rx_full | input | 1 | Receive register full level |
| evt_tone | input | 1 | High-tone detect source |
| nmi_in | input | 1 | Non-maskable interrupt request |
| line_num | input | LINE_W | Current video line |
| pix_fetch | input | 1 | Video logic wants a memory fetch this cycle |
| irq_n | output | 1 | Maskable interrupt, active low |
| ram_access_ok | output | 1 | Video fetch granted memory |
| status_rd | output | 8 | Readable status byte |

## Verification
On every cycle, the assertions check four things. The NMI state always blocks `ram_access_ok`, and it stays set until the release write. The edge-latched flags stay set until their clear bit is written. The level flags track their inputs one cycle late, and vsync follows the last-line and line-zero rules. Other behaviours can only be shown by the bench's scenarios. These are the masking of IRQ by an enable byte written earlier, the set-wins race between a fresh edge and a clear, and the fact that writes to unused offsets leave all state alone.

// File: rtl/intc_pkg.sv
package intc_pkg;

    localparam int NSRC       = 5;
    localparam int SRC_LSB    = 2;
    localparam int CLR_RTC    = 4;
    localparam int CLR_TONE   = 6;
    localparam int CLR_NMI    = 7;
    localparam int NLATCH     = 3;   // rtc, tone, nmi
    localparam int LAT_RTC    = 0;
    localparam int LAT_TONE   = 1;
    localparam int LAT_NMI    = 2;

    typedef struct packed {
        logic tone;
        logic rx_full;
        logic tx_empty;
        logic rtc;
        logic vsync;
    } src_t;

    typedef struct packed {
        logic en_wr;
        logic clr_wr;
    } bus_op_t;

    function automatic logic [7:0] pack_status(src_t s, logic nmi, logic master);
        return {nmi, s, 1'b0, master};
    endfunction

endpackage

// File: rtl/intc_bus.sv
module intc_bus
    import intc_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int EN_ADDR  = 0,
    parameter int CLR_ADDR = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_we,
    output logic [NSRC-1:0]   enable,
    output logic [NLATCH-1:0] clr
);
    bus_op_t op;

    always_comb begin
        op.en_wr  = bus_we && (bus_addr == ADDR_W'(EN_ADDR));
        op.clr_wr = bus_we && (bus_addr == ADDR_W'(CLR_ADDR));
    end

    always_ff @(posedge clk) begin
        if (rst)
            enable <= '0;
        else if (op.en_wr)
            enable <= bus_wdata[SRC_LSB +: NSRC];
    end

    always_comb begin
        clr          = '0;
        clr[LAT_RTC]  = op.clr_wr && bus_wdata[CLR_RTC];
        clr[LAT_TONE] = op.clr_wr && bus_wdata[CLR_TONE];
        clr[LAT_NMI]  = op.clr_wr && bus_wdata[CLR_NMI];
    end
endmodule

// File: rtl/intc_edge_latch.sv
module intc_edge_latch (
    input  logic clk,
    input  logic rst,
    input  logic evt,
    input  logic clr,
    output logic flag
);
    logic prev;
    logic rise;

    assign rise = evt && !prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev <= 1'b0;
            flag <= 1'b0;
        end else begin
            prev <= evt;
            if (rise)
                flag <= 1'b1;   // a fresh event beats a same-cycle clear
            else if (clr)
                flag <= 1'b0;
        end
    end
endmodule

// File: rtl/intc_vsync.sv
module intc_vsync #(
    parameter int LINE_W    = 9,
    parameter int LAST_LINE = 255
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LINE_W-1:0] line_num,
    output logic              vsync_flag
);
    localparam logic [LINE_W-1:0] LAST = LINE_W'(LAST_LINE);

    always_ff @(posedge clk) begin
        if (rst)
            vsync_flag <= 1'b0;
        else if (line_num == '0)
            vsync_flag <= 1'b0;
        else if (line_num == LAST)
            vsync_flag <= 1'b1;
    end
endmodule

// File: rtl/intc_top.sv
module intc_top
    import intc_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int LINE_W    = 9,
    parameter int LAST_LINE = 255,
    parameter int EN_ADDR   = 0,
    parameter int CLR_ADDR  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_we,
    input  logic              evt_rtc,
    input  logic              evt_tx_empty,
    input  logic              evt_rx_full,
    input  logic              evt_tone,
    input  logic              nmi_in,
    input  logic [LINE_W-1:0] line_num,
    input  logic              pix_fetch,
    output logic              irq_n,
    output logic              ram_access_ok,
    output logic [7:0]        status_rd
);
    logic [NSRC-1:0]   enable;
    logic [NLATCH-1:0] clr;
    logic [NLATCH-1:0] lat_in;
    logic [NLATCH-1:0] lat_q;
    logic              vs_q;
    logic              tx_q;
    logic              rx_q;
    src_t              src;
    logic [NSRC-1:0]   pending;
    logic              master;

    intc_bus #(.ADDR_W(ADDR_W), .EN_ADDR(EN_ADDR), .CLR_ADDR(CLR_ADDR)) u_bus (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .enable(enable), .clr(clr)
    );

    assign lat_in[LAT_RTC]  = evt_rtc;
    assign lat_in[LAT_TONE] = evt_tone;
    assign lat_in[LAT_NMI]  = nmi_in;

    for (genvar i = 0; i < NLATCH; i++) begin : g_lat
        intc_edge_latch u_lat (
            .clk(clk), .rst(rst), .evt(lat_in[i]), .clr(clr[i]), .flag(lat_q[i])
        );
    end

    intc_vsync #(.LINE_W(LINE_W), .LAST_LINE(LAST_LINE)) u_vs (
        .clk(clk), .rst(rst), .line_num(line_num), .vsync_flag(vs_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q <= 1'b0;
            rx_q <= 1'b0;
        end else begin
            tx_q <= evt_tx_empty;
            rx_q <= evt_rx_full;
        end
    end

    always_comb begin
        src.vsync    = vs_q;
        src.rtc      = lat_q[LAT_RTC];
        src.tx_empty = tx_q;
        src.rx_full  = rx_q;
        src.tone     = lat_q[LAT_TONE];
    end

    assign pending       = src & enable;
    assign master        = |pending;
    assign irq_n         = !master;
    assign ram_access_ok = pix_fetch && !lat_q[LAT_NMI];
    assign status_rd     = pack_status(src, lat_q[LAT_NMI], master);
endmodule

// File: rtl/intc_chk.sv
module intc_chk #(
    parameter int ADDR_W    = 4,
    parameter int LINE_W    = 9,
    parameter int LAST_LINE = 255,
    parameter int CLR_ADDR  = 5
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_wdata,
    input logic              bus_we,
    input logic              evt_tx_empty,
    input logic              evt_rx_full,
    input logic [LINE_W-1:0] line_num,
    input logic              pix_fetch,
    input logic              irq_n,
    input logic              ram_access_ok,
    input logic [7:0]        status_rd
);
    logic clr_wr;
    assign clr_wr = bus_we && (bus_addr == ADDR_W'(CLR_ADDR));

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (status_rd == 8'h00 && irq_n));

    a_r7_nmi_blocks_fetch: assert property (@(posedge clk) disable iff (rst)
        status_rd[7] |-> !ram_access_ok);

    a_r7_nmi_held: assert property (@(posedge clk) disable iff (rst)
        (status_rd[7] && !(clr_wr && bus_wdata[7])) |=> status_rd[7]);

    a_r5_rtc_sticky: assert property (@(posedge clk) disable iff (rst)
        (status_rd[3] && !(clr_wr && bus_wdata[4])) |=> status_rd[3]);

    a_r5_tone_sticky: assert property (@(posedge clk) disable iff (rst)
        (status_rd[6] && !(clr_wr && bus_wdata[6])) |=> status_rd[6]);

    a_r4_tx_follows: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (status_rd[4] == $past(evt_tx_empty)));

    a_r4_rx_follows: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (status_rd[5] == $past(evt_rx_full)));

    a_r6_vsync_set: assert property (@(posedge clk) disable iff (rst)
        (line_num == LINE_W'(LAST_LINE)) |=> status_rd[2]);

    a_r6_vsync_clear: assert property (@(posedge clk) disable iff (rst)
        (line_num == '0) |=> !status_rd[2]);

    a_r3_master_irq: assert property (@(posedge clk) disable iff (rst)
        status_rd[0] == !irq_n);

    a_r3_bit1_zero: assert property (@(posedge clk) disable iff (rst)
        !status_rd[1]);
endmodule

bind intc_top intc_chk #(
    .ADDR_W(ADDR_W), .LINE_W(LINE_W), .LAST_LINE(LAST_LINE), .CLR_ADDR(CLR_ADDR)
) u_chk (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .evt_tx_empty(evt_tx_empty), .evt_rx_full(evt_rx_full),
    .line_num(line_num), .pix_fetch(pix_fetch), .irq_n(irq_n),
    .ram_access_ok(ram_access_ok), .status_rd(status_rd)
);

// File: tb/sim_intc_top.sv
module sim_intc_top;
    localparam int ADDR_W = 4;
    localparam int LINE_W = 9;
    localparam int LAST   = 255;
    localparam int NLINES = 312;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic bus_we = 1'b0;
    logic evt_rtc = 0, evt_tx_empty = 0, evt_rx_full = 0, evt_tone = 0, nmi_in = 0;
    logic [LINE_W-1:0] line_num = '0;
    logic pix_fetch = 1'b0;
    logic irq_n, ram_access_ok;
    logic [7:0] status_rd;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // bench model of the requirements
    logic [4:0] m_en;
    logic m_vs, m_rtc, m_tone, m_tx, m_rx, m_nmi, p_rtc, p_tone, p_nmi;

    always #4 clk = ~clk;

    intc_top #(.ADDR_W(ADDR_W), .LINE_W(LINE_W), .LAST_LINE(LAST)) u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .evt_rtc(evt_rtc), .evt_tx_empty(evt_tx_empty),
        .evt_rx_full(evt_rx_full), .evt_tone(evt_tone), .nmi_in(nmi_in),
        .line_num(line_num), .pix_fetch(pix_fetch), .irq_n(irq_n),
        .ram_access_ok(ram_access_ok), .status_rd(status_rd)
    );

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [7:0] exp_status();
        logic [4:0] s;
        s = {m_tone, m_rx, m_tx, m_rtc, m_vs};
        return {m_nmi, s, 1'b0, |(s & m_en)};
    endfunction

    task automatic model_reset();
        m_en = '0; m_vs = 0; m_rtc = 0; m_tone = 0; m_tx = 0; m_rx = 0;
        m_nmi = 0; p_rtc = 0; p_tone = 0; p_nmi = 0;
    endtask

    // advance model with current inputs, clock, then compare
    task automatic step();
        logic cw;
        cw = bus_we && bus_addr == 4'd5;
        if (bus_we && bus_addr == 4'd0) m_en = bus_wdata[6:2];
        if (line_num == 0) m_vs = 0; else if (line_num == LINE_W'(LAST)) m_vs = 1;
        if (evt_rtc && !p_rtc) m_rtc = 1; else if (cw && bus_wdata[4]) m_rtc = 0;
        if (evt_tone && !p_tone) m_tone = 1; else if (cw && bus_wdata[6]) m_tone = 0;
        if (nmi_in && !p_nmi) m_nmi = 1; else if (cw && bus_wdata[7]) m_nmi = 0;
        p_rtc = evt_rtc; p_tone = evt_tone; p_nmi = nmi_in;
        m_tx = evt_tx_empty; m_rx = evt_rx_full;
        @(posedge clk); #2;
        chk("R3 master", {7'd0, status_rd[0]}, {7'd0, exp_status()[0]});
        chk("R2 irq_n", {7'd0, irq_n}, {7'd0, ~|({m_tone, m_rx, m_tx, m_rtc, m_vs} & m_en)});
        chk("R4 level", {6'd0, status_rd[5:4]}, {6'd0, m_rx, m_tx});
        chk("R5 latched", {6'd0, status_rd[6], status_rd[3]}, {6'd0, m_tone, m_rtc});
        chk("R6 vsync", {7'd0, status_rd[2]}, {7'd0, m_vs});
        chk("R7 nmi", {7'd0, status_rd[7]}, {7'd0, m_nmi});
        chk("R7 ram_access_ok", {7'd0, ram_access_ok}, {7'd0, pix_fetch && !m_nmi});
        chk("R3 bit1", {7'd0, status_rd[1]}, 8'd0);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        bus_we = 1; bus_addr = a; bus_wdata = d;
        step();
        bus_we = 0;
    endtask

    initial begin
        void'($urandom(32'd1234));
        model_reset();
        repeat (3) @(posedge clk);
        #2;
        chk("R1 reset status", status_rd, 8'h00);
        chk("R1 reset irq_n", {7'd0, irq_n}, 8'd1);
        rst = 0;
        line_num = 9'd5;
        step();

        // R2: enable all, raise tx level
        wr(4'd0, 8'h7C);
        evt_tx_empty = 1; step();
        chk("R2 irq low with tx enabled", {7'd0, irq_n}, 8'd0);
        // R8: write to unused offset and clear write must not touch enable/tx
        wr(4'd3, 8'h00);
        wr(4'd5, 8'h3F);
        chk("R8 enable/tx kept", {7'd0, irq_n}, 8'd0);
        evt_tx_empty = 0; step();

        // R5: race edge and clear in the same cycle -> set wins
        evt_rtc = 1; bus_we = 1; bus_addr = 4'd5; bus_wdata = 8'h10; step();
        bus_we = 0;
        chk("R5 set beats clear", {7'd0, status_rd[3]}, 8'd1);
        evt_rtc = 0; step();
        chk("R5 sticky after input low", {7'd0, status_rd[3]}, 8'd1);
        wr(4'd5, 8'h10);
        chk("R5 cleared", {7'd0, status_rd[3]}, 8'd0);

        // R7: nmi sets, held, blocks fetch, released by bit 7
        pix_fetch = 1; nmi_in = 1; step();
        nmi_in = 0; step();
        chk("R7 fetch blocked", {7'd0, ram_access_ok}, 8'd0);
        wr(4'd5, 8'h80);
        chk("R7 fetch restored", {7'd0, ram_access_ok}, 8'd1);

        // R6: line boundaries
        line_num = LINE_W'(LAST); step();
        chk("R6 set at last line", {7'd0, status_rd[2]}, 8'd1);
        line_num = 9'd7; step();
        chk("R6 held", {7'd0, status_rd[2]}, 8'd1);
        line_num = 9'd0; step();
        chk("R6 cleared at line 0", {7'd0, status_rd[2]}, 8'd0);

        // random phase with running line counter
        for (int i = 0; i < 4000; i++) begin
            line_num = (line_num + 1 >= NLINES) ? '0 : line_num + 1;
            evt_rtc      = ($urandom % 8) == 0;
            evt_tone     = ($urandom % 8) == 0;
            evt_tx_empty = $urandom % 2;
            evt_rx_full  = $urandom % 2;
            nmi_in       = ($urandom % 32) == 0;
            pix_fetch    = $urandom % 2;
            bus_we       = ($urandom % 4) == 0;
            bus_addr     = ($urandom % 2) ? 4'(($urandom % 3) * 5 / 2 * 2) : 4'($urandom);
            bus_wdata    = 8'($urandom);
            step();
        end
        bus_we = 0;
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule